// File: doc/BRIEF.md
# Prescaled Counter with Coherent Byte Reads

This block is a 16-bit up-counter. Its count enable comes from a chain of two stages. A two-bit selector picks one tick source: none, every bus clock, a fixed-rate enable pulse, or the rising edges of an external clock input. A power-of-two prescaler then divides that source by 1 to 128. The counter wraps around at the top of its range.

Software sees the count as two byte-wide read strobes. The first byte read takes a snapshot of the whole 16-bit value, and later reads return that snapshot until the other byte has been read. A high and low byte read in either order therefore belong to the same instant. This holds even though the live counter keeps advancing underneath.

Writing either counter byte clears the count. Writing the control register drops any snapshot that is still pending.

Top module: `cnt16_timer`

## Requirements
- R1: After reset the count reads 0x0000 and no snapshot is pending.
- R2: With source select 2'b00 the count holds its value and the prescaler stays cleared, whatever happens on the fixed-tick and external inputs.
- R3: With source select 2'b01 every bus clock cycle is one source tick, so N cycles at prescale code n add floor(N / 2^n) to the count.
- R4: With source select 2'b10 each bus cycle in which `fixed_tick` is high is one source tick.
- R5: With source select 2'b11 `ext_clk` passes through a two-flop synchronizer, and each rising edge gives exactly one source tick. A level held high gives no further ticks. The input may toggle at up to a quarter of the bus clock rate.
- R6: Prescale code n (3 bits) divides the source ticks by 2^n, from code 3'b000 (divide by 1) to 3'b111 (divide by 128). After a clear, or after a period with the source off, the first count step comes only after a full 2^n source ticks.
- R7: The count steps from 0xFFFF to 0x0000.
- R8: `rd_hi` returns bits 15:8 and `rd_lo` returns bits 7:0 on `rd_data` in the same cycle; `rd_data` is 0 when neither or both strobes are high. A read with no snapshot pending returns the live byte and captures all 16 bits. While the snapshot is pending, reads of either byte return the captured value, including repeated reads of the first byte. The snapshot is released by the read of the opposite byte.
- R9: A pulse on `wr_hi`, `wr_lo` or `ctrl_wr` discards a pending snapshot, so the next read returns live data.
- R10: A pulse on `wr_hi` or `wr_lo` clears the whole count to 0x0000 at the next clock edge, taking priority over a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Tick source: 00 off, 01 bus clock, 10 fixed tick, 11 external edge |
| psc_code | input | 3 | Prescale exponent n; divide by 2^n |
| fixed_tick | input | 1 | Fixed-rate enable, one source tick per high cycle |
| ext_clk | input | 1 | Asynchronous external clock, at most a quarter of the bus rate |
| rd_hi | input | 1 | Read strobe for count bits 15:8 |
| rd_lo | input | 1 | Read strobe for count bits 7:0 |
| wr_hi | input | 1 | Write strobe to the high count byte (clears count) |
| wr_lo | input | 1 | Write strobe to the low count byte (clears count) |
| ctrl_wr | input | 1 | Write strobe to the control register (drops snapshot) |
| rd_data | output | 8 | Byte returned for the active read strobe |

## Verification
The hardest case to reach from the ports is a pending snapshot whose contents differ from the live count, with the two values straddling a carry into the high byte. Only then does a wrong byte source show up. The stimulus first runs the count to 0x00FF. It reads the low byte and then lets the counter run past 0x0100 before reading again. It checks that a repeated first-byte read and the opposite-byte read both return the old value, while the next fresh read returns the new one. The same straddling setup is used with a control write and with a counter write in between, which proves that the snapshot is dropped.

// File: rtl/cnt16_pkg.sv
package cnt16_pkg;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'b00,
    SRC_BUS   = 2'b01,
    SRC_FIXED = 2'b10,
    SRC_EXT   = 2'b11
  } src_sel_e;

  localparam int DEF_CNT_W  = 16;
  localparam int DEF_PSC_W  = 3;
  localparam int DEF_SYNC_N = 2;

endpackage

// File: rtl/cnt16_src_sel.sv
module cnt16_src_sel
  import cnt16_pkg::*;
#(
  parameter int SYNC_N = DEF_SYNC_N
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       fixed_tick,
  input  logic       ext_clk,
  output logic       src_tick,
  output logic       src_off
);

  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              ext_level;
  logic              ext_rise;
  src_sel_e          sel;

  generate
    if (SYNC_N == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ext_clk;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-2:0], ext_clk};
      end
    end
  endgenerate

  assign ext_level = sync_q[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= ext_level;
  end

  assign ext_rise = ext_level & ~prev_q;

  assign sel = src_sel_e'(src_sel);

  always_comb begin
    case (sel)
      SRC_BUS:   src_tick = 1'b1;
      SRC_FIXED: src_tick = fixed_tick;
      SRC_EXT:   src_tick = ext_rise;
      default:   src_tick = 1'b0;
    endcase
  end

  assign src_off = (sel == SRC_NONE);

  // A detected edge is never followed by a second one on the next cycle
  assert_ext_single_tick_R5: assert property (
    @(posedge clk) disable iff (!rst_n) ext_rise |=> !ext_rise
  ) else $error("external edge produced back-to-back ticks");

endmodule

// File: rtl/cnt16_prescaler.sv
module cnt16_prescaler
  import cnt16_pkg::*;
#(
  parameter int PSC_W = DEF_PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic             clr,
  input  logic [PSC_W-1:0] psc_code,
  output logic             pre_tick
);

  localparam int PRE_W = (1 << PSC_W) - 1;
  localparam logic [PRE_W:0] ONE_WIDE = 1;

  function automatic logic [PRE_W-1:0] div_mask(input logic [PSC_W-1:0] code);
    logic [PRE_W:0] span;
    span = (ONE_WIDE << code) - ONE_WIDE;
    return span[PRE_W-1:0];
  endfunction

  function automatic logic at_terminal(input logic [PRE_W-1:0] cnt,
                                       input logic [PSC_W-1:0] code);
    return (cnt & div_mask(code)) == div_mask(code);
  endfunction

  logic [PRE_W-1:0] pre_q;

  assign pre_tick = src_tick & at_terminal(pre_q, psc_code);

  always_ff @(posedge clk) begin
    if (!rst_n)        pre_q <= '0;
    else if (clr)      pre_q <= '0;
    else if (src_tick) pre_q <= pre_q + 1'b1;
  end

  assert_pre_cleared_R6: assert property (
    @(posedge clk) disable iff (!rst_n) clr |=> (pre_q == '0)
  ) else $error("prescaler not cleared");

  assert_pre_holds_R6: assert property (
    @(posedge clk) disable iff (!rst_n) (!clr && !src_tick) |=> $stable(pre_q)
  ) else $error("prescaler moved without a source tick");

endmodule

// File: rtl/cnt16_core.sv
module cnt16_core
  import cnt16_pkg::*;
#(
  parameter int W = DEF_CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] STEP = 1;

  function automatic logic [W-1:0] advance(input logic [W-1:0] v);
    return v + STEP;
  endfunction

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= advance(cnt_q);
  end

  assign count = cnt_q;

  assert_clear_wins_R10: assert property (
    @(posedge clk) disable iff (!rst_n) clr |=> (cnt_q == '0)
  ) else $error("count not cleared by write");

  assert_step_wraps_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
      (inc && !clr && (cnt_q == '1)) |=> (cnt_q == '0)
  ) else $error("count did not wrap to zero");

  assert_hold_when_idle_R2: assert property (
    @(posedge clk) disable iff (!rst_n) (!inc && !clr) |=> $stable(cnt_q)
  ) else $error("count moved without a tick");

endmodule

// File: rtl/cnt16_rd_latch.sv
module cnt16_rd_latch
  import cnt16_pkg::*;
#(
  parameter int W = DEF_CNT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   live,
  input  logic           rd_hi,
  input  logic           rd_lo,
  input  logic           discard,
  output logic [W/2-1:0] rd_data
);

  localparam int H = W / 2;

  logic         pend_q;
  logic         first_hi_q;
  logic [W-1:0] snap_q;
  logic [W-1:0] view;
  logic         rd_one;
  logic         open_rd;
  logic         close_rd;

  assign rd_one   = rd_hi ^ rd_lo;
  assign open_rd  = rd_one & ~pend_q;
  assign close_rd = rd_one & pend_q & (rd_hi != first_hi_q);
  assign view     = pend_q ? snap_q : live;

  always_comb begin
    if (!rd_one)    rd_data = '0;
    else if (rd_hi) rd_data = view[W-1:H];
    else            rd_data = view[H-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      first_hi_q <= 1'b0;
      snap_q     <= '0;
    end else if (discard) begin
      pend_q <= 1'b0;
    end else if (open_rd) begin
      pend_q     <= 1'b1;
      first_hi_q <= rd_hi;
      snap_q     <= live;
    end else if (close_rd) begin
      pend_q <= 1'b0;
    end
  end

  assert_discard_drops_R9: assert property (
    @(posedge clk) disable iff (!rst_n) discard |=> !pend_q
  ) else $error("snapshot survived a write");

  assert_open_captures_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
      (open_rd && !discard) |=> (pend_q && (snap_q == $past(live)))
  ) else $error("first read did not capture the count");

  assert_snapshot_held_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
      (pend_q && !discard && !close_rd) |=> (pend_q && $stable(snap_q))
  ) else $error("pending snapshot changed");

endmodule

// File: rtl/cnt16_timer.sv
module cnt16_timer
  import cnt16_pkg::*;
#(
  parameter int CNT_W  = DEF_CNT_W,
  parameter int PSC_W  = DEF_PSC_W,
  parameter int SYNC_N = DEF_SYNC_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         src_sel,
  input  logic [PSC_W-1:0]   psc_code,
  input  logic               fixed_tick,
  input  logic               ext_clk,
  input  logic               rd_hi,
  input  logic               rd_lo,
  input  logic               wr_hi,
  input  logic               wr_lo,
  input  logic               ctrl_wr,
  output logic [CNT_W/2-1:0] rd_data
);

  logic             src_tick;
  logic             src_off;
  logic             cnt_tick;
  logic             cnt_clr;
  logic             pre_clr;
  logic             snap_drop;
  logic [CNT_W-1:0] count;

  assign cnt_clr   = wr_hi | wr_lo;
  assign pre_clr   = cnt_clr | src_off;
  assign snap_drop = cnt_clr | ctrl_wr;

  cnt16_src_sel #(.SYNC_N(SYNC_N)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sel   (src_sel),
    .fixed_tick(fixed_tick),
    .ext_clk   (ext_clk),
    .src_tick  (src_tick),
    .src_off   (src_off)
  );

  cnt16_prescaler #(.PSC_W(PSC_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_tick(src_tick),
    .clr     (pre_clr),
    .psc_code(psc_code),
    .pre_tick(cnt_tick)
  );

  cnt16_core #(.W(CNT_W)) u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (cnt_tick),
    .clr  (cnt_clr),
    .count(count)
  );

  cnt16_rd_latch #(.W(CNT_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .live   (count),
    .rd_hi  (rd_hi),
    .rd_lo  (rd_lo),
    .discard(snap_drop),
    .rd_data(rd_data)
  );

  assert_off_no_tick_R2: assert property (
    @(posedge clk) disable iff (!rst_n) src_off |-> !cnt_tick
  ) else $error("count tick with source off");

  assert_tick_needs_source_R6: assert property (
    @(posedge clk) disable iff (!rst_n) cnt_tick |-> src_tick
  ) else $error("prescaler ticked without a source tick");

endmodule

// File: tb/cnt16_timer_tb.sv
`timescale 1ns/1ps
module cnt16_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [2:0] psc_code = 3'd0;
  logic       fixed_tick = 1'b0;
  logic       ext_clk = 1'b0;
  logic       rd_hi = 1'b0;
  logic       rd_lo = 1'b0;
  logic       wr_hi = 1'b0;
  logic       wr_lo = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] rd_data;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cnt16_timer u_dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .psc_code(psc_code),
    .fixed_tick(fixed_tick), .ext_clk(ext_clk), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .ctrl_wr(ctrl_wr), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic rd_byte(input bit hi, output logic [7:0] b);
    if (hi) rd_hi = 1'b1; else rd_lo = 1'b1;
    #2 b = rd_data;
    @(negedge clk);
    rd_hi = 1'b0;
    rd_lo = 1'b0;
  endtask

  task automatic rd_word(output logic [15:0] w);
    logic [7:0] lo_b, hi_b;
    rd_byte(1'b0, lo_b);
    rd_byte(1'b1, hi_b);
    w = {hi_b, lo_b};
  endtask

  task automatic clear_frozen();
    src_sel = 2'b00;
    wr_lo = 1'b1;
    @(negedge clk);
    wr_lo = 1'b0;
  endtask

  task automatic run(input logic [1:0] sel, input logic [2:0] psc, input int n);
    src_sel = sel;
    psc_code = psc;
    repeat (n) @(negedge clk);
    src_sel = 2'b00;
  endtask

  task automatic t_reset();
    logic [15:0] w;
    rd_word(w);
    check("R1 count after reset", w, 16'h0000);
  endtask

  task automatic t_bus_prescale();
    logic [15:0] w;
    for (int c = 0; c < 8; c += 3) begin
      clear_frozen();
      run(2'b01, 3'(c), 300);
      rd_word(w);
      check("R3 bus count with prescale", w, 16'(300 >> c));
    end
    clear_frozen();
    run(2'b01, 3'd7, 300);
    rd_word(w);
    check("R6 divide by 128", w, 16'd2);
    clear_frozen();
    run(2'b01, 3'd2, 3);
    rd_word(w);
    check("R6 no step before full period", w, 16'd0);
    run(2'b01, 3'd2, 4);
    rd_word(w);
    check("R6 step after full period", w, 16'd1);
  endtask

  task automatic t_off();
    logic [15:0] w;
    clear_frozen();
    run(2'b01, 3'd0, 10);
    src_sel = 2'b00;
    for (int i = 0; i < 12; i++) begin
      fixed_tick = 1'b1;
      ext_clk = ~ext_clk;
      repeat (4) @(negedge clk);
    end
    fixed_tick = 1'b0;
    ext_clk = 1'b0;
    repeat (4) @(negedge clk);
    rd_word(w);
    check("R2 source off holds count", w, 16'd10);
  endtask

  task automatic t_fixed();
    logic [15:0] w;
    clear_frozen();
    src_sel = 2'b10;
    psc_code = 3'd1;
    for (int i = 0; i < 10; i++) begin
      fixed_tick = 1'b1;
      @(negedge clk);
      fixed_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
    src_sel = 2'b00;
    rd_word(w);
    check("R4 fixed tick pulses counted", w, 16'd5);
  endtask

  task automatic t_ext();
    logic [15:0] w;
    clear_frozen();
    ext_clk = 1'b0;
    src_sel = 2'b11;
    psc_code = 3'd0;
    for (int i = 0; i < 12; i++) begin
      ext_clk = 1'b1;
      repeat ((i == 11) ? 20 : 4) @(negedge clk);
      ext_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
    src_sel = 2'b00;
    rd_word(w);
    check("R5 one tick per external rising edge", w, 16'd12);
  endtask

  task automatic t_wrap();
    logic [15:0] w;
    clear_frozen();
    run(2'b01, 3'd0, 65535);
    rd_word(w);
    check("R7 count reaches top", w, 16'hFFFF);
    run(2'b01, 3'd0, 1);
    rd_word(w);
    check("R7 wrap to zero", w, 16'h0000);
  endtask

  task automatic t_coherent();
    logic [7:0] b;
    clear_frozen();
    src_sel = 2'b01;
    psc_code = 3'd0;
    repeat (255) @(negedge clk);
    rd_byte(1'b0, b);
    check("R8 first low read is live", {8'h00, b}, 16'h00FF);
    repeat (3) @(negedge clk);
    rd_byte(1'b0, b);
    check("R8 repeat low read returns snapshot", {8'h00, b}, 16'h00FF);
    rd_byte(1'b1, b);
    check("R8 high read returns snapshot", {8'h00, b}, 16'h0000);
    rd_byte(1'b1, b);
    check("R8 fresh high read is live", {8'h00, b}, 16'h0001);
    rd_byte(1'b0, b);
    check("R8 low after high-first returns snapshot", {8'h00, b}, 16'h0005);
    src_sel = 2'b00;
    rd_hi = 1'b1;
    rd_lo = 1'b1;
    #2 check("R8 both strobes give zero", {8'h00, rd_data}, 16'h0000);
    @(negedge clk);
    rd_hi = 1'b0;
    rd_lo = 1'b0;
  endtask

  task automatic t_discard();
    logic [7:0] b;
    clear_frozen();
    run(2'b01, 3'd0, 255);
    rd_byte(1'b0, b);
    run(2'b01, 3'd0, 6);
    ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
    rd_byte(1'b1, b);
    check("R9 control write drops snapshot", {8'h00, b}, 16'h0001);
    rd_byte(1'b0, b);
    check("R9 new snapshot after control write", {8'h00, b}, 16'h0005);
    clear_frozen();
    run(2'b01, 3'd0, 255);
    rd_byte(1'b0, b);
    run(2'b01, 3'd0, 6);
    wr_hi = 1'b1;
    @(negedge clk);
    wr_hi = 1'b0;
    run(2'b01, 3'd0, 16'h0203);
    rd_byte(1'b1, b);
    check("R9 counter write drops snapshot", {8'h00, b}, 16'h0002);
    rd_byte(1'b0, b);
    check("R9 low byte after counter write", {8'h00, b}, 16'h0003);
  endtask

  task automatic t_write_clear();
    logic [15:0] w;
    clear_frozen();
    run(2'b01, 3'd0, 100);
    wr_hi = 1'b1;
    @(negedge clk);
    wr_hi = 1'b0;
    rd_word(w);
    check("R10 high write clears count", w, 16'h0000);
    src_sel = 2'b01;
    repeat (40) @(negedge clk);
    wr_lo = 1'b1;
    @(negedge clk);
    wr_lo = 1'b0;
    src_sel = 2'b00;
    rd_word(w);
    check("R10 low write clears while counting", w, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bus_prescale();
    t_off();
    t_fixed();
    t_ext();
    t_wrap();
    t_coherent();
    t_discard();
    t_write_clear();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all-R actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule